// File: doc/BRIEF.md
# Request Phase Sequencer

This block executes one decoded work request at a time for a data-mover channel. A request arrives on a valid/ready port. It carries an identifier, a command byte, source and destination addresses, a length, a doorbell address, an attribute byte and a data word, and a small array of semaphore command words. The sequencer checks the request and then walks it through four ordered phases. It first waits for the presync semaphore condition. It then hands the transfer to an external mover. Next it issues each postsync semaphore command in turn. Last, it writes the doorbell. When the request asks for it, the sequencer then returns a two-field completion record.

The sequencer moves no data and walks no descriptor lists. Those jobs belong to the mover behind the start/done handshake. Semaphore state is held by an external unit. That unit receives whole command words and answers with a grant once the command's condition has been met. The byte lane of a narrow doorbell write is placed by the low address bits.

Top module: `sqr_top`

## Requirements
- R1: `req_ready` is high only when no request is in flight. A request is taken on a cycle with `req_valid` and `req_ready` both high. No further request is taken until the previous one has finished, including acceptance of its completion record.
- R2: For each request the activity follows a fixed order: the presync semaphore command, the transfer, the postsync semaphore commands, the doorbell write and then the completion record. Phases that do not apply are skipped. At most one of `sem_req_valid`, `dma_start`, `db_valid` and `rsp_valid` is high in any cycle.
- R3: Command bits [1:0] give the transfer kind: 0 means none (the transfer phase is skipped), 1 means toward the device (`dma_to_dev`=1) and 2 means from the device (`dma_to_dev`=0). Command bit 3 drives `dma_bulk` (1 bulk, 0 list). The addresses and the length are passed through unchanged. `dma_start` stays high until `dma_done`. Command bits 7, 6, 5 and 2 have no effect.
- R4: In a semaphore word, bit 31 enables the word and bit 22 marks it presync (1) or postsync (0). A word with bit 31 clear is never issued. The single presync word is issued before the transfer. Postsync words are issued after it in ascending array index. Each word is presented whole on `sem_req_cmd` until `sem_grant`.
- R5: Doorbell attribute bit 7 enables the write. Attribute bits [1:0] select the width: 0 is 32-bit with `db_be`=1111, 1 is 16-bit with `db_be`=0011 shifted left by address bits [1:0], and 2 is 8-bit with `db_be`=0001 shifted the same way. The low data bits of that width are placed on the enabled byte lanes, and all other bits of `db_data` are zero.
- R6: When command bit 4 is set, a successful request ends with a completion record. Its `rsp_id` equals the request identifier and its `rsp_code` is 0.
- R7: The following faults are checked in priority order. Transfer kind 3 gives code 1. An enabled doorbell with width 3 gives code 2. An enabled doorbell with a misaligned address (32-bit with address bits [1:0] not 0, or 16-bit with address bit 0 set) gives code 3. More than one enabled presync word gives code 4. A faulty request issues no semaphore command, no transfer and no doorbell. It always returns a completion record with its code, whatever command bit 4 says.
- R8: Every outgoing request (semaphore, transfer, doorbell and completion) holds its valid high and its payload stable until it is answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_id | input | ID_W | Request identifier |
| req_cmd | input | 8 | Command byte |
| req_src | input | ADDR_W | Transfer source address |
| req_dst | input | ADDR_W | Transfer destination address |
| req_len | input | LEN_W | Transfer length |
| req_db_addr | input | ADDR_W | Doorbell address |
| req_db_attr | input | 8 | Doorbell attribute byte |
| req_db_data | input | 32 | Doorbell data |
| req_sem | input | NUM_SEM*32 | Semaphore words, word 0 in the low bits |
| sem_req_valid | output | 1 | Semaphore command presented |
| sem_req_cmd | output | 32 | Semaphore command word |
| sem_grant | input | 1 | Semaphore condition met and command done |
| dma_start | output | 1 | Transfer requested, held until done |
| dma_to_dev | output | 1 | Direction: 1 toward device |
| dma_bulk | output | 1 | 1 bulk, 0 list |
| dma_src | output | ADDR_W | Source address |
| dma_dst | output | ADDR_W | Destination address |
| dma_len | output | LEN_W | Length |
| dma_done | input | 1 | Transfer finished |
| db_valid | output | 1 | Doorbell write presented |
| db_addr | output | ADDR_W | Doorbell address |
| db_data | output | 32 | Lane-placed doorbell data |
| db_be | output | 4 | Byte enables |
| db_ready | input | 1 | Doorbell write accepted |
| rsp_valid | output | 1 | Completion record presented |
| rsp_id | output | ID_W | Identifier of the finished request |
| rsp_code | output | 16 | Completion code |
| rsp_ready | input | 1 | Completion record accepted |

## Verification
Two functions can fall on the same cycle. One is a completion record waiting on `rsp_ready`. The other is the next request already offered on `req_valid`. The bench provokes this by holding `rsp_ready` low for several cycles while it keeps a second request asserted. It then judges, in every stalled cycle, that `req_ready` stays low and that none of the second request's semaphore or transfer activity appears before the first record has been accepted. Per-channel answer delays are varied between test groups. This lets a postsync command follow its predecessor's grant without a gap, and lets a transfer be answered in its first cycle.

// File: rtl/sqr_pkg.sv
package sqr_pkg;

    localparam int SEM_W        = 32;
    localparam int SEM_EN_BIT   = 31;
    localparam int SEM_PRE_BIT  = 22;
    localparam int CMD_BULK_BIT = 3;
    localparam int CMD_RSP_BIT  = 4;
    localparam int DB_EN_BIT    = 7;
    localparam int CODE_W       = 16;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_CHECK = 3'd1,
        PH_PRE   = 3'd2,
        PH_DMA   = 3'd3,
        PH_POST  = 3'd4,
        PH_DB    = 3'd5,
        PH_RSP   = 3'd6
    } phase_e;

    typedef enum logic [1:0] {
        XF_NONE     = 2'd0,
        XF_TO_DEV   = 2'd1,
        XF_FROM_DEV = 2'd2,
        XF_BAD      = 2'd3
    } xfer_e;

    typedef enum logic [1:0] {
        DW_32  = 2'd0,
        DW_16  = 2'd1,
        DW_8   = 2'd2,
        DW_BAD = 2'd3
    } dbw_e;

    localparam logic [CODE_W-1:0] CC_OK        = 16'd0;
    localparam logic [CODE_W-1:0] CC_BAD_XFER  = 16'd1;
    localparam logic [CODE_W-1:0] CC_BAD_DBW   = 16'd2;
    localparam logic [CODE_W-1:0] CC_DB_ALIGN  = 16'd3;
    localparam logic [CODE_W-1:0] CC_MULTI_PRE = 16'd4;

endpackage

// File: rtl/sqr_sem_scan.sv
module sqr_sem_scan #(
    parameter int NUM_SEM = 4,
    parameter int IDX_W   = 2
) (
    input  logic [NUM_SEM-1:0] en,
    input  logic [NUM_SEM-1:0] pre,
    output logic [NUM_SEM-1:0] pre_mask,
    output logic [NUM_SEM-1:0] post_mask,
    output logic [IDX_W-1:0]   pre_idx,
    output logic               multi_pre
);

    for (genvar g = 0; g < NUM_SEM; g++) begin : g_slot
        assign pre_mask[g]  = en[g] & pre[g];
        assign post_mask[g] = en[g] & ~pre[g];
    end

    always_comb begin
        int cnt;
        cnt     = 0;
        pre_idx = '0;
        for (int i = NUM_SEM - 1; i >= 0; i--) begin
            if (pre_mask[i]) begin
                pre_idx = IDX_W'(i);
                cnt     = cnt + 1;
            end
        end
        multi_pre = (cnt > 1);
    end

endmodule

// File: rtl/sqr_fault_chk.sv
module sqr_fault_chk
    import sqr_pkg::*;
(
    input  logic [1:0]        xfer,
    input  logic              db_en,
    input  logic [1:0]        db_w,
    input  logic [1:0]        addr_lo,
    input  logic              multi_pre,
    output logic [CODE_W-1:0] code
);

    logic misaligned;

    always_comb begin
        case (db_w)
            DW_32:   misaligned = (addr_lo != 2'b00);
            DW_16:   misaligned = addr_lo[0];
            default: misaligned = 1'b0;
        endcase
    end

    always_comb begin
        if (xfer == XF_BAD)
            code = CC_BAD_XFER;
        else if (db_en && (db_w == DW_BAD))
            code = CC_BAD_DBW;
        else if (db_en && misaligned)
            code = CC_DB_ALIGN;
        else if (multi_pre)
            code = CC_MULTI_PRE;
        else
            code = CC_OK;
    end

endmodule

// File: rtl/sqr_db_lane.sv
module sqr_db_lane
    import sqr_pkg::*;
(
    input  logic [1:0]  db_w,
    input  logic [1:0]  addr_lo,
    input  logic [31:0] data_in,
    output logic [3:0]  be,
    output logic [31:0] data_out
);

    logic [4:0] sh;
    assign sh = {addr_lo, 3'b000};

    always_comb begin
        case (db_w)
            DW_32: begin
                be       = 4'b1111;
                data_out = data_in;
            end
            DW_16: begin
                be       = 4'b0011 << addr_lo;
                data_out = {16'h0000, data_in[15:0]} << sh;
            end
            DW_8: begin
                be       = 4'b0001 << addr_lo;
                data_out = {24'h000000, data_in[7:0]} << sh;
            end
            default: begin
                be       = 4'b0000;
                data_out = 32'h0;
            end
        endcase
    end

endmodule

// File: rtl/sqr_top.sv
module sqr_top
    import sqr_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int LEN_W   = 32,
    parameter int ID_W    = 16,
    parameter int NUM_SEM = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ID_W-1:0]         req_id,
    input  logic [7:0]              req_cmd,
    input  logic [ADDR_W-1:0]       req_src,
    input  logic [ADDR_W-1:0]       req_dst,
    input  logic [LEN_W-1:0]        req_len,
    input  logic [ADDR_W-1:0]       req_db_addr,
    input  logic [7:0]              req_db_attr,
    input  logic [31:0]             req_db_data,
    input  logic [NUM_SEM*32-1:0]   req_sem,
    output logic                    sem_req_valid,
    output logic [31:0]             sem_req_cmd,
    input  logic                    sem_grant,
    output logic                    dma_start,
    output logic                    dma_to_dev,
    output logic                    dma_bulk,
    output logic [ADDR_W-1:0]       dma_src,
    output logic [ADDR_W-1:0]       dma_dst,
    output logic [LEN_W-1:0]        dma_len,
    input  logic                    dma_done,
    output logic                    db_valid,
    output logic [ADDR_W-1:0]       db_addr,
    output logic [31:0]             db_data,
    output logic [3:0]              db_be,
    input  logic                    db_ready,
    output logic                    rsp_valid,
    output logic [ID_W-1:0]         rsp_id,
    output logic [15:0]             rsp_code,
    input  logic                    rsp_ready
);

    localparam int IDX_W = (NUM_SEM > 1) ? $clog2(NUM_SEM) : 1;

    typedef struct packed {
        phase_e                        ph;
        logic [IDX_W-1:0]              idx;
        logic [CODE_W-1:0]             code;
        logic [ID_W-1:0]               id;
        logic [1:0]                    xfer;
        logic                          bulk;
        logic                          want_rsp;
        logic [ADDR_W-1:0]             src;
        logic [ADDR_W-1:0]             dst;
        logic [LEN_W-1:0]              len;
        logic [ADDR_W-1:0]             dba;
        logic                          db_en;
        logic [1:0]                    db_w;
        logic [31:0]                   dbd;
        logic [NUM_SEM-1:0][SEM_W-1:0] sem;
    } seq_t;

    seq_t s_d, s_q;

    // Command and attribute bits that carry no behaviour here.
    logic unused_bits;
    assign unused_bits = ^{req_cmd[7:5], req_cmd[2], req_db_attr[6:2]};

    logic [NUM_SEM-1:0] en_v, pre_v, pre_mask, post_mask;
    logic [IDX_W-1:0]   pre_idx, first_post, rem_idx;
    logic               multi_pre, has_pre, has_post, rem_any;
    logic [CODE_W-1:0]  chk_code;

    for (genvar g = 0; g < NUM_SEM; g++) begin : g_bits
        assign en_v[g]  = s_q.sem[g][SEM_EN_BIT];
        assign pre_v[g] = s_q.sem[g][SEM_PRE_BIT];
    end

    sqr_sem_scan #(
        .NUM_SEM (NUM_SEM),
        .IDX_W   (IDX_W)
    ) i_scan (
        .en        (en_v),
        .pre       (pre_v),
        .pre_mask  (pre_mask),
        .post_mask (post_mask),
        .pre_idx   (pre_idx),
        .multi_pre (multi_pre)
    );

    sqr_fault_chk i_chk (
        .xfer      (s_q.xfer),
        .db_en     (s_q.db_en),
        .db_w      (s_q.db_w),
        .addr_lo   (s_q.dba[1:0]),
        .multi_pre (multi_pre),
        .code      (chk_code)
    );

    sqr_db_lane i_lane (
        .db_w     (s_q.db_w),
        .addr_lo  (s_q.dba[1:0]),
        .data_in  (s_q.dbd),
        .be       (db_be),
        .data_out (db_data)
    );

    assign has_pre  = |pre_mask;
    assign has_post = |post_mask;

    // Lowest postsync slot overall, and lowest one above the current slot.
    always_comb begin
        first_post = '0;
        rem_idx    = '0;
        rem_any    = 1'b0;
        for (int i = NUM_SEM - 1; i >= 0; i--) begin
            if (post_mask[i]) begin
                first_post = IDX_W'(i);
                if (i > int'(s_q.idx)) begin
                    rem_idx = IDX_W'(i);
                    rem_any = 1'b1;
                end
            end
        end
    end

    // First applicable phase at or after stage lvl (0 pre .. 4 response).
    function automatic phase_e pick(input int lvl, input logic p_pre, input logic p_dma,
                                    input logic p_post, input logic p_db, input logic p_rsp);
        if (lvl <= 0 && p_pre)  return PH_PRE;
        if (lvl <= 1 && p_dma)  return PH_DMA;
        if (lvl <= 2 && p_post) return PH_POST;
        if (lvl <= 3 && p_db)   return PH_DB;
        if (lvl <= 4 && p_rsp)  return PH_RSP;
        return PH_IDLE;
    endfunction

    logic do_dma;
    assign do_dma = (s_q.xfer != XF_NONE);

    always_comb begin
        s_d = s_q;
        case (s_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    s_d.ph       = PH_CHECK;
                    s_d.idx      = '0;
                    s_d.code     = CC_OK;
                    s_d.id       = req_id;
                    s_d.xfer     = req_cmd[1:0];
                    s_d.bulk     = req_cmd[CMD_BULK_BIT];
                    s_d.want_rsp = req_cmd[CMD_RSP_BIT];
                    s_d.src      = req_src;
                    s_d.dst      = req_dst;
                    s_d.len      = req_len;
                    s_d.dba      = req_db_addr;
                    s_d.db_en    = req_db_attr[DB_EN_BIT];
                    s_d.db_w     = req_db_attr[1:0];
                    s_d.dbd      = req_db_data;
                    s_d.sem      = req_sem;
                end
            end
            PH_CHECK: begin
                if (chk_code != CC_OK) begin
                    s_d.code = chk_code;
                    s_d.ph   = PH_RSP;
                end else begin
                    s_d.ph  = pick(0, has_pre, do_dma, has_post, s_q.db_en, s_q.want_rsp);
                    s_d.idx = (s_d.ph == PH_PRE) ? pre_idx : first_post;
                end
            end
            PH_PRE: begin
                if (sem_grant) begin
                    s_d.ph  = pick(1, has_pre, do_dma, has_post, s_q.db_en, s_q.want_rsp);
                    s_d.idx = first_post;
                end
            end
            PH_DMA: begin
                if (dma_done) begin
                    s_d.ph  = pick(2, has_pre, do_dma, has_post, s_q.db_en, s_q.want_rsp);
                    s_d.idx = first_post;
                end
            end
            PH_POST: begin
                if (sem_grant) begin
                    if (rem_any)
                        s_d.idx = rem_idx;
                    else
                        s_d.ph = pick(3, has_pre, do_dma, has_post, s_q.db_en, s_q.want_rsp);
                end
            end
            PH_DB: begin
                if (db_ready)
                    s_d.ph = pick(4, has_pre, do_dma, has_post, s_q.db_en, s_q.want_rsp);
            end
            PH_RSP: begin
                if (rsp_ready)
                    s_d.ph = PH_IDLE;
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign req_ready     = (s_q.ph == PH_IDLE);
    assign sem_req_valid = (s_q.ph == PH_PRE) || (s_q.ph == PH_POST);
    assign sem_req_cmd   = s_q.sem[s_q.idx];
    assign dma_start     = (s_q.ph == PH_DMA);
    assign dma_to_dev    = (s_q.xfer == XF_TO_DEV);
    assign dma_bulk      = s_q.bulk;
    assign dma_src       = s_q.src;
    assign dma_dst       = s_q.dst;
    assign dma_len       = s_q.len;
    assign db_valid      = (s_q.ph == PH_DB);
    assign db_addr       = s_q.dba;
    assign rsp_valid     = (s_q.ph == PH_RSP);
    assign rsp_id        = s_q.id;
    assign rsp_code      = s_q.code;

endmodule

// File: rtl/sqr_checker.sv
module sqr_checker #(
    parameter int ID_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            sem_req_valid,
    input logic [31:0]     sem_req_cmd,
    input logic            sem_grant,
    input logic            dma_start,
    input logic            dma_done,
    input logic            db_valid,
    input logic [3:0]      db_be,
    input logic            db_ready,
    input logic            rsp_valid,
    input logic [ID_W-1:0] rsp_id,
    input logic [15:0]     rsp_code,
    input logic            rsp_ready
);

    p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !(sem_req_valid || dma_start || db_valid || rsp_valid));

    p_one_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({sem_req_valid, dma_start, db_valid, rsp_valid}) <= 1);

    p_dma_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dma_start && dma_done |=> !dma_start);

    p_sem_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sem_req_valid |-> sem_req_cmd[31]);

    p_be_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
        db_valid |-> ($countones(db_be) == 1 || $countones(db_be) == 2 || $countones(db_be) == 4));

    p_sem_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sem_req_valid && !sem_grant |=> sem_req_valid && $stable(sem_req_cmd));

    p_db_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        db_valid && !db_ready |=> db_valid && $stable(db_be));

    p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_id) && $stable(rsp_code));

endmodule

bind sqr_top sqr_checker #(.ID_W(ID_W)) i_sqr_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .sem_req_valid (sem_req_valid),
    .sem_req_cmd   (sem_req_cmd),
    .sem_grant     (sem_grant),
    .dma_start     (dma_start),
    .dma_done      (dma_done),
    .db_valid      (db_valid),
    .db_be         (db_be),
    .db_ready      (db_ready),
    .rsp_valid     (rsp_valid),
    .rsp_id        (rsp_id),
    .rsp_code      (rsp_code),
    .rsp_ready     (rsp_ready)
);

// File: tb/test_sqr_top.sv
module test_sqr_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [15:0]  req_id = '0;
    logic [7:0]   req_cmd = '0;
    logic [63:0]  req_src = '0, req_dst = '0, req_db_addr = '0;
    logic [31:0]  req_len = '0, req_db_data = '0;
    logic [7:0]   req_db_attr = '0;
    logic [127:0] req_sem = '0;
    logic         sem_req_valid, dma_start, dma_to_dev, dma_bulk, db_valid, rsp_valid;
    logic [31:0]  sem_req_cmd, dma_len, db_data;
    logic [63:0]  dma_src, dma_dst, db_addr;
    logic [3:0]   db_be;
    logic [15:0]  rsp_id, rsp_code;
    logic         sem_grant = 1'b0, dma_done = 1'b0, db_ready = 1'b0, rsp_ready = 1'b0;

    always #2 clk = ~clk;

    sqr_top i_sqr_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_id(req_id), .req_cmd(req_cmd), .req_src(req_src), .req_dst(req_dst),
        .req_len(req_len), .req_db_addr(req_db_addr), .req_db_attr(req_db_attr),
        .req_db_data(req_db_data), .req_sem(req_sem),
        .sem_req_valid(sem_req_valid), .sem_req_cmd(sem_req_cmd), .sem_grant(sem_grant),
        .dma_start(dma_start), .dma_to_dev(dma_to_dev), .dma_bulk(dma_bulk),
        .dma_src(dma_src), .dma_dst(dma_dst), .dma_len(dma_len), .dma_done(dma_done),
        .db_valid(db_valid), .db_addr(db_addr), .db_data(db_data), .db_be(db_be),
        .db_ready(db_ready), .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_code(rsp_code),
        .rsp_ready(rsp_ready)
    );

    // Expected activity: kind 0 semaphore, 1 transfer, 2 doorbell, 3 completion.
    int           exp_kind[$];
    logic [191:0] exp_pay[$];
    string        exp_req[$];
    int nchk = 0, nfail = 0, cyc = 0;
    int sem_dly = 0, dma_dly = 0, db_dly = 0, rsp_dly = 0;
    int sem_cnt = 0, dma_cnt = 0, db_cnt = 0, rsp_cnt = 0;

    task automatic expect_ev(input int k, input logic [191:0] p, input string r);
        exp_kind.push_back(k);
        exp_pay.push_back(p);
        exp_req.push_back(r);
    endtask

    task automatic observe(input int k, input logic [191:0] p);
        nchk++;
        if (exp_kind.size() == 0) begin
            nfail++;
            $display("FAIL R2: unexpected kind %0d payload %h, expected nothing", k, p);
        end else begin
            int           ek = exp_kind.pop_front();
            logic [191:0] ep = exp_pay.pop_front();
            string        er = exp_req.pop_front();
            if (ek != k || ep != p) begin
                nfail++;
                $display("FAIL %s: kind %0d payload %h, expected kind %0d payload %h", er, k, p, ek, ep);
            end
        end
    endtask

    function automatic logic [31:0] sw(input logic en, input logic pre, input logic [2:0] op,
                                        input logic [4:0] idx, input logic [11:0] val);
        return {en, 4'b0000, op, 1'b0, pre, 1'b0, idx, 4'b0000, val};
    endfunction

    // Behavioural model of one request, then drive it.
    task automatic send(input logic [15:0] id, input logic [7:0] cmd, input logic [7:0] attr,
                        input logic [63:0] dba, input logic [31:0] dbd, input logic [127:0] sem);
        int npre = 0;
        int code = 0;
        int bytes;
        logic [1:0] w = attr[1:0];
        logic [1:0] a = dba[1:0];
        logic [63:0] src = {32'hA5000000, 16'h0, id};
        logic [63:0] dst = {32'h5A000000, 16'h0, ~id};
        logic [31:0] len = 32'h100 + 32'(id);
        for (int i = 0; i < 4; i++)
            if (sem[i*32+31] && sem[i*32+22]) npre++;
        if (cmd[1:0] == 2'd3) code = 1;
        else if (attr[7] && w == 2'd3) code = 2;
        else if (attr[7] && ((w == 2'd0 && a != 2'd0) || (w == 2'd1 && a[0]))) code = 3;
        else if (npre > 1) code = 4;
        if (code != 0) begin
            expect_ev(3, {160'h0, id, 16'(code)}, "R7");
        end else begin
            for (int i = 0; i < 4; i++)
                if (sem[i*32+31] && sem[i*32+22]) expect_ev(0, {160'h0, sem[i*32+:32]}, "R4");
            if (cmd[1:0] != 2'd0)
                expect_ev(1, {30'h0, cmd[1:0] == 2'd1, cmd[3], len, src, dst}, "R3");
            for (int i = 0; i < 4; i++)
                if (sem[i*32+31] && !sem[i*32+22]) expect_ev(0, {160'h0, sem[i*32+:32]}, "R4");
            if (attr[7]) begin
                logic [3:0]  be;
                logic [63:0] d;
                bytes = (w == 2'd0) ? 4 : (w == 2'd1) ? 2 : 1;
                be = 4'(((1 << bytes) - 1) << a);
                d  = (64'(dbd) & ((64'h1 << (8 * bytes)) - 1)) << (8 * a);
                expect_ev(2, {92'h0, be, d[31:0], dba}, "R5");
            end
            if (cmd[4]) expect_ev(3, {160'h0, id, 16'h0}, "R6");
        end
        @(negedge clk);
        req_id = id; req_cmd = cmd; req_db_attr = attr; req_db_addr = dba;
        req_db_data = dbd; req_sem = sem; req_src = src; req_dst = dst; req_len = len;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Responders and cycle monitor, all away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (int'(sem_req_valid) + int'(dma_start) + int'(db_valid) + int'(rsp_valid) > 1) begin
                nchk++; nfail++;
                $display("FAIL R2: %b%b%b%b active, expected at most one",
                         sem_req_valid, dma_start, db_valid, rsp_valid);
            end
            if (rsp_valid) begin
                nchk++;
                if (req_ready) begin
                    nfail++;
                    $display("FAIL R1: req_ready=%b during pending completion, expected 0", req_ready);
                end
            end
            if (sem_req_valid && sem_cnt >= sem_dly) begin
                sem_grant = 1'b1; sem_cnt = 0; observe(0, {160'h0, sem_req_cmd});
            end else begin
                sem_grant = 1'b0; sem_cnt = sem_req_valid ? sem_cnt + 1 : 0;
            end
            if (dma_start && dma_cnt >= dma_dly) begin
                dma_done = 1'b1; dma_cnt = 0;
                observe(1, {30'h0, dma_to_dev, dma_bulk, dma_len, dma_src, dma_dst});
            end else begin
                dma_done = 1'b0; dma_cnt = dma_start ? dma_cnt + 1 : 0;
            end
            if (db_valid && db_cnt >= db_dly) begin
                db_ready = 1'b1; db_cnt = 0; observe(2, {92'h0, db_be, db_data, db_addr});
            end else begin
                db_ready = 1'b0; db_cnt = db_valid ? db_cnt + 1 : 0;
            end
            if (rsp_valid && rsp_cnt >= rsp_dly) begin
                rsp_ready = 1'b1; rsp_cnt = 0; observe(3, {160'h0, rsp_id, rsp_code});
            end else begin
                rsp_ready = 1'b0; rsp_cnt = rsp_valid ? rsp_cnt + 1 : 0;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            nfail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    task automatic drain();
        while (exp_kind.size() != 0 || !req_ready) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        logic [31:0] s_off;
        s_off = sw(1'b0, 1'b0, 3'd0, 5'd0, 12'd0);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        nchk++;
        if (req_ready !== 1'b1 || {sem_req_valid, dma_start, db_valid, rsp_valid} !== 4'b0) begin
            nfail++;
            $display("FAIL R1: reset ready=%b valids=%b%b%b%b, expected 1 0000",
                     req_ready, sem_req_valid, dma_start, db_valid, rsp_valid);
        end

        // R3 R6: to-device bulk, completion only.
        send(16'h0011, 8'h19, 8'h00, 64'h0, 32'h0, {4{s_off}});
        // R4 R5: from-device list, presync in slot 2, postsync 0 and 3, disabled presync in 1, 32-bit doorbell.
        send(16'h0022, 8'h12, 8'h80, 64'h1000_0040, 32'hCAFEF00D,
             {sw(1,0,3'd3,5'd7,12'h003), sw(1,1,3'd4,5'd2,12'h010),
              sw(0,1,3'd5,5'd1,12'h0aa), sw(1,0,3'd2,5'd4,12'h001)});
        sem_dly = 2; dma_dly = 3; db_dly = 1;
        // R5: no transfer, 16-bit doorbell at offset 2, no completion.
        send(16'h0033, 8'h00, 8'h81, 64'h2000_0002, 32'h1234ABCD, {4{s_off}});
        // R5: 8-bit doorbell at offset 3.
        send(16'h0044, 8'h01, 8'h82, 64'h2000_0003, 32'h7788_99EE, {4{s_off}});
        // R3: reserved command bits set, behaviour unchanged.
        send(16'h0055, 8'hF5, 8'h00, 64'h0, 32'h0, {s_off, s_off, s_off, sw(1,0,3'd2,5'd9,12'h004)});
        sem_dly = 0; dma_dly = 0; db_dly = 0;
        // R7: faults, each in priority order.
        send(16'h0061, 8'h03, 8'h00, 64'h0, 32'h0, {4{s_off}});
        send(16'h0062, 8'h11, 8'h83, 64'h0, 32'h0, {4{s_off}});
        send(16'h0063, 8'h11, 8'h03, 64'h0, 32'h5, {4{s_off}});
        send(16'h0064, 8'h01, 8'h80, 64'h2, 32'h0, {4{s_off}});
        send(16'h0065, 8'h01, 8'h81, 64'h1, 32'h0, {4{s_off}});
        send(16'h0066, 8'h02, 8'h00, 64'h0, 32'h0,
             {s_off, sw(1,1,3'd6,5'd1,12'h0), s_off, sw(1,1,3'd4,5'd0,12'h2)});
        send(16'h0067, 8'h03, 8'h83, 64'h1, 32'h0,
             {s_off, sw(1,1,3'd6,5'd1,12'h0), s_off, sw(1,1,3'd4,5'd0,12'h2)});
        drain();

        // R1: completion held back while the next request waits.
        rsp_dly = 6;
        fork
            begin
                send(16'h0071, 8'h11, 8'h00, 64'h0, 32'h0, {4{s_off}});
                send(16'h0072, 8'h1A, 8'h00, 64'h0, 32'h0,
                     {s_off, s_off, sw(1,1,3'd5,5'd3,12'h1), s_off});
            end
        join
        drain();

        nchk++;
        if (exp_kind.size() != 0) begin
            nfail++;
            $display("FAIL R2: %0d expected events left, expected 0", exp_kind.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule